// File: doc/BRIEF.md
# Dual-Mode 18-Bit Adder/Subtractor

This block is a purely combinational 18-bit arithmetic unit. It adds, subtracts or increments two operand words. A single mode input selects how the words are read: as one's-complement numbers, where the carry out of the sign position wraps around into the least significant position, or as two's-complement numbers, where that carry is dropped. The outputs are the result word, an overflow flag and the raw carry out of the sign position. All three follow the current inputs within the same cycle, and the block holds no state.

In one's-complement mode the all-ones word is the negative zero. The block replaces a negative-zero result with positive zero, with two exceptions. The first is negative zero plus negative zero. The second is negative zero minus positive zero. Both of these keep the negative zero. An increment never raises overflow, so a loop counter built on it cannot disturb an overflow flag kept by the surrounding logic.

Top module: `addsub18`

## Requirements
- R1: The operation code `op` selects the operation as follows: 2'b00 adds, 2'b01 subtracts (`opa` minus `opb`), 2'b10 increments `opa` and ignores `opb`, and 2'b11 behaves exactly like 2'b00.
- R2: When `twos_mode`=1 and the operation is add, `result` equals (`opa`+`opb`) mod 2^18 and `carry_out` is bit 18 of that sum.
- R3: When `twos_mode`=1 and the operation is subtract, the block forms `opa` + ~`opb` + 1. `result` is the low 18 bits of that sum and `carry_out` is its bit 18, which is 1 exactly when `opa` >= `opb` as unsigned values.
- R4: When `twos_mode`=0 and the operation is add, the block forms `opa`+`opb`. Bit 18 of that sum is added back into the low 18 bits to give `result` (end-around carry). `carry_out` reports that bit 18.
- R5: When `twos_mode`=0 and the operation is subtract, the block adds `opa` to ~`opb`, with the same end-around carry as R4. No separate carry-in is used.
- R6: For add and subtract in either mode, `ovf` is 1 exactly when the carry into bit 17 (the sign bit) differs from the carry out of bit 17. The carry out used here is taken before any end-around carry.
- R7: When `twos_mode`=0, a result of 18'o777777 is replaced by 18'o000000, except in the cases listed in R8.
- R8: When `twos_mode`=0 and `opa`=18'o777777, an add with `opb`=18'o777777 and a subtract with `opb`=18'o000000 both return 18'o777777.
- R9: The increment adds one in the current mode. When `twos_mode`=0, 18'o777776 gives 18'o000000 and 18'o777777 gives 18'o000001. When `twos_mode`=1, 18'o777777 gives 18'o000000 with `carry_out`=1.
- R10: The increment always gives `ovf`=0, including on 18'o377777 in two's-complement mode.
- R11: 18'o123456 plus 18'o666666 gives 18'o012345 when `twos_mode`=0 and 18'o012344 when `twos_mode`=1. In both modes `carry_out`=1 and `ovf`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 18 | Left operand; bit 17 is the sign |
| opb | input | 18 | Right operand; not used by increment |
| op | input | 2 | Operation code (R1) |
| twos_mode | input | 1 | 1 selects two's complement, 0 selects one's complement |
| result | output | 18 | Result word |
| ovf | output | 1 | Signed overflow flag |
| carry_out | output | 1 | Carry out of the sign position, taken before any end-around carry |

## Verification
The stimulus mixes uniformly random word pairs with operands drawn from a small set of edge values: both zeros, the largest positive word, the most negative word, and minus one in each notation. Uniform pairs check that the end-around carry and the dropped carry really separate the two modes. The edge values reach the sign-boundary overflows that random data seldom hits, and they reach the negative-zero folding and its two exceptions. Directed increments of the words just below and at the wrap point show the difference between the modes. The increment of the largest positive word shows that overflow stays low. The unused operation code is applied alongside add, so that any difference from add shows up in the outputs.

// File: rtl/addsub18_pkg.sv
`timescale 1ns/1ps
package addsub18_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_INC = 2'b10,
    OP_ALT = 2'b11
  } op_e;

  // Returns the right-hand addend that the chain actually sees.
  function automatic logic [17:0] pick_addend(input op_e code, input logic [17:0] b);
    logic [17:0] v;
    case (code)
      OP_SUB:  v = ~b;
      OP_INC:  v = 18'd1;
      default: v = b;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/addsub18_opsel.sv
`timescale 1ns/1ps
module addsub18_opsel
  import addsub18_pkg::*;
#(
  parameter int W = 18
) (
  input  logic [W-1:0] b_in,
  input  logic [1:0]   op_code,
  input  logic         twos,
  output logic [W-1:0] b_eff,
  output logic         cin,
  output logic         is_inc
);
  op_e code;

  always_comb begin
    code   = op_e'(op_code);
    is_inc = (code == OP_INC);
    cin    = twos && (code == OP_SUB);
    case (code)
      OP_SUB:  b_eff = ~b_in;
      OP_INC:  b_eff = W'(1);
      default: b_eff = b_in;
    endcase
  end
endmodule

// File: rtl/addsub18_chain.sv
`timescale 1ns/1ps
module addsub18_chain #(
  parameter int W = 18
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_into_msb,
  output logic         c_out
);
  logic [W:0] c;

  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]  = x[i] ^ y[i] ^ c[i];
    assign c[i+1]  = (x[i] & y[i]) | (x[i] & c[i]) | (y[i] & c[i]);
  end

  assign c_into_msb = c[W-1];
  assign c_out      = c[W];
endmodule

// File: rtl/addsub18_wrap.sv
`timescale 1ns/1ps
module addsub18_wrap #(
  parameter int W = 18
) (
  input  logic [W-1:0] sum,
  input  logic         c_out,
  input  logic         ones,
  input  logic         keep_negz,
  output logic [W-1:0] res
);
  logic [W-1:0] t;
  logic [W-1:0] res_raw;
  logic         eac;
  logic         negz;

  assign eac  = ones & c_out;
  assign t[0] = eac;

  for (genvar i = 0; i < W; i++) begin : g_inc
    assign res_raw[i] = sum[i] ^ t[i];
    if (i < W - 1) begin : g_prop
      assign t[i+1] = sum[i] & t[i];
    end
  end

  assign negz = &res_raw;
  assign res  = (ones && negz && !keep_negz) ? '0 : res_raw;
endmodule

// File: rtl/addsub18.sv
`timescale 1ns/1ps
module addsub18 #(
  parameter int W = 18
) (
  input  logic [17:0] opa,
  input  logic [17:0] opb,
  input  logic [1:0]  op,
  input  logic        twos_mode,
  output logic [17:0] result,
  output logic        ovf,
  output logic        carry_out
);
  logic [W-1:0] b_eff;
  logic         cin;
  logic         is_inc;
  logic [W-1:0] raw_sum;
  logic         c_into_msb;
  logic         c_msb_out;
  logic         keep_negz;

  addsub18_opsel #(.W(W)) u_opsel (
    .b_in   (opb),
    .op_code(op),
    .twos   (twos_mode),
    .b_eff  (b_eff),
    .cin    (cin),
    .is_inc (is_inc)
  );

  addsub18_chain #(.W(W)) u_chain (
    .x         (opa),
    .y         (b_eff),
    .cin       (cin),
    .sum       (raw_sum),
    .c_into_msb(c_into_msb),
    .c_out     (c_msb_out)
  );

  // Both exception cases show up as all-ones on both chain inputs.
  assign keep_negz = (&opa) && (&b_eff);

  addsub18_wrap #(.W(W)) u_wrap (
    .sum      (raw_sum),
    .c_out    (c_msb_out),
    .ones     (!twos_mode),
    .keep_negz(keep_negz),
    .res      (result)
  );

  assign ovf       = !is_inc && (c_into_msb ^ c_msb_out);
  assign carry_out = c_msb_out;
endmodule

// File: rtl/addsub18_chk.sv
`timescale 1ns/1ps
module addsub18_chk #(
  parameter int W = 18
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [1:0]   op,
  input logic         twos_mode,
  input logic [W-1:0] result,
  input logic         ovf,
  input logic         carry_out
);
  logic known;
  logic is_add;
  logic [W:0] wide_sum;

  always_comb begin
    known    = !$isunknown({opa, opb, op, twos_mode, result, ovf, carry_out});
    is_add   = (op == 2'b00) || (op == 2'b11);
    wide_sum = {1'b0, opa} + {1'b0, opb};
    if (known) begin
      if (op == 2'b10)
        AST_INC_NO_OVF: assert (!ovf) else $error("increment raised overflow"); // R10
      if (!twos_mode && (&result))
        AST_ONES_NEGZ_ONLY_EXC: assert ((&opa) && ((is_add && (&opb)) || (op == 2'b01 && opb == '0))) else $error("negative zero escaped"); // R7
      if (twos_mode && is_add)
        AST_TWOS_ADD_SUM: assert (result == wide_sum[W-1:0] && carry_out == wide_sum[W]) else $error("two's add mismatch"); // R2
      if (twos_mode && is_add)
        AST_TWOS_ADD_OVF: assert (ovf == ((opa[W-1] == opb[W-1]) && (result[W-1] != opa[W-1]))) else $error("two's add overflow"); // R6
      if (twos_mode && op == 2'b01)
        AST_TWOS_SUB_CARRY: assert (carry_out == (opa >= opb)) else $error("two's sub carry"); // R3
      if (!twos_mode && op == 2'b10 && (&opa))
        AST_ONES_INC_NEGZ: assert (result == W'(1)) else $error("one's increment of -0"); // R9
    end
  end
endmodule

bind addsub18 addsub18_chk #(.W(18)) chk_i (
  .opa      (opa),
  .opb      (opb),
  .op       (op),
  .twos_mode(twos_mode),
  .result   (result),
  .ovf      (ovf),
  .carry_out(carry_out)
);

// File: tb/addsub18_tb_top.sv
`timescale 1ns/1ps
module addsub18_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] opa = '0;
  logic [17:0] opb = '0;
  logic [1:0]  op = 2'b00;
  logic        twos_mode = 1'b0;
  logic [17:0] result;
  logic        ovf;
  logic        carry_out;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  addsub18 dut_i (
    .opa(opa), .opb(opb), .op(op), .twos_mode(twos_mode),
    .result(result), .ovf(ovf), .carry_out(carry_out)
  );

  // Reference model: {carry, ovf, result}
  function automatic logic [19:0] model(input logic [17:0] a, input logic [17:0] b,
                                        input logic [1:0] code, input logic tw);
    logic [17:0] eb;
    logic [18:0] s;
    logic [17:0] r;
    logic        cin, v;
    eb  = (code == 2'b01) ? ~b : (code == 2'b10) ? 18'd1 : b;
    cin = tw && (code == 2'b01);
    s   = {1'b0, a} + {1'b0, eb} + {18'd0, cin};
    v   = (code != 2'b10) && (a[17] == eb[17]) && (s[17] != a[17]);
    if (tw) r = s[17:0];
    else begin
      r = s[17:0] + {17'd0, s[18]};
      if (r == 18'o777777 && !(a == 18'o777777 && eb == 18'o777777)) r = '0;
    end
    return {s[18], v, r};
  endfunction

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%o expected=%o (a=%o b=%o op=%0d twos=%0d)",
               req, act, exp, opa, opb, op, twos_mode);
    end
  endtask

  task automatic apply(input logic [17:0] a, input logic [17:0] b,
                       input logic [1:0] code, input logic tw);
    @(posedge clk);
    #1;
    opa = a; opb = b; op = code; twos_mode = tw;
    @(negedge clk);
  endtask

  function automatic string tag_of(input logic [1:0] code, input logic tw);
    if (code == 2'b10) return "R9";
    if (code == 2'b01) return tw ? "R3" : "R5";
    return tw ? "R2" : "R4";
  endfunction

  task automatic run_model(input logic [17:0] a, input logic [17:0] b,
                           input logic [1:0] code, input logic tw);
    logic [19:0] e;
    apply(a, b, code, tw);
    e = model(a, b, code, tw);
    chk(tag_of(code, tw), result, e[17:0]);
    chk((code == 2'b10) ? "R10" : "R6", {17'd0, ovf}, {17'd0, e[18]});
    chk("R1", {17'd0, carry_out}, {17'd0, e[19]});
  endtask

  function automatic logic [17:0] pick();
    logic [2:0] k;
    k = 3'($urandom % 8);
    case (k)
      3'd0: return 18'o000000;
      3'd1: return 18'o777777;
      3'd2: return 18'o777776;
      3'd3: return 18'o377777;
      3'd4: return 18'o400000;
      3'd5: return 18'o000001;
      default: return 18'($urandom);
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20481));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2", result, 18'o000000);
    chk("R6", {17'd0, ovf}, 18'd0);
    rst_n = 1'b1;

    // R11 worked example in both modes
    apply(18'o123456, 18'o666666, 2'b00, 1'b0);
    chk("R11", result, 18'o012345);
    chk("R11", {17'd0, carry_out}, 18'd1);
    apply(18'o123456, 18'o666666, 2'b00, 1'b1);
    chk("R11", result, 18'o012344);
    chk("R11", {17'd0, ovf}, 18'd0);

    // R7 fold and R8 exceptions
    apply(18'o000005, 18'o777772, 2'b00, 1'b0);
    chk("R7", result, 18'o000000);
    apply(18'o777777, 18'o777777, 2'b00, 1'b0);
    chk("R8", result, 18'o777777);
    apply(18'o777777, 18'o000000, 2'b01, 1'b0);
    chk("R8", result, 18'o777777);
    apply(18'o777777, 18'o000000, 2'b00, 1'b0);
    chk("R7", result, 18'o000000);

    // R9 / R10 increments
    apply(18'o777776, 18'o123123, 2'b10, 1'b0);
    chk("R9", result, 18'o000000);
    apply(18'o777777, 18'o000000, 2'b10, 1'b0);
    chk("R9", result, 18'o000001);
    apply(18'o777777, 18'o555555, 2'b10, 1'b1);
    chk("R9", result, 18'o000000);
    chk("R9", {17'd0, carry_out}, 18'd1);
    apply(18'o377777, 18'o000000, 2'b10, 1'b1);
    chk("R10", {17'd0, ovf}, 18'd0);
    chk("R10", result, 18'o400000);

    // R6 overflow at the sign boundary
    apply(18'o377777, 18'o000001, 2'b00, 1'b1);
    chk("R6", {17'd0, ovf}, 18'd1);
    apply(18'o400000, 18'o400000, 2'b00, 1'b1);
    chk("R6", {17'd0, ovf}, 18'd1);
    apply(18'o400000, 18'o000001, 2'b01, 1'b0);
    chk("R6", {17'd0, ovf}, 18'd1);

    // R3 carry on subtract, R5 one's subtract
    apply(18'o000005, 18'o000007, 2'b01, 1'b1);
    chk("R3", result, 18'o777776);
    chk("R3", {17'd0, carry_out}, 18'd0);
    apply(18'o000007, 18'o000005, 2'b01, 1'b0);
    chk("R5", result, 18'o000002);

    // R1: code 3 equals add
    apply(18'o070707, 18'o707070, 2'b11, 1'b1);
    chk("R1", result, 18'o777777);
    run_model(18'o777777, 18'o777777, 2'b11, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      logic [17:0] a, b;
      a = pick();
      b = pick();
      run_model(a, b, 2'($urandom % 4), 1'($urandom));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule